// File: doc/BRIEF.md
# Channel-Status Block Decoder

This block sits behind a biphase-mark receiver front end. It collects the 192 channel-status bits of an audio block, one bit per frame, in the serial order in which they arrive, and turns the start of the first status byte into two flags for downstream logic. The first flag marks audio or non-audio content. In consumer mode the second flag marks copy protection. In professional mode it carries the low emphasis bit. In professional mode the whole block is also protected by an 8-bit CRC, and the block checks it.

The front end presents each status bit with a valid strobe and marks the first bit of every block. A mode input says whether the block is consumer or professional. The block sets its flags only after a block is complete and, in professional mode, only after that block has passed its check. It reports every completed block with a one-cycle pulse and keeps a CRC-error flag that lasts until the next completed block.

Top module: `cs_status_decoder`

## Requirements
- R1: While reset is active and after it, until the first completed block, `audio_o`, `copy_emph_o`, `crc_err_o` and `blk_done_o` are all 0.
- R2: Bits are numbered in arrival order from 0. On an accepted block, `audio_o` takes the inverse of bit 1: 1 means audio and 0 means non-audio.
- R3: In consumer mode (`prof_mode_i` = 0, sampled with bit 0), `copy_emph_o` takes the inverse of bit 2: 1 means copying is inhibited.
- R4: In professional mode (`prof_mode_i` = 1), `copy_emph_o` takes bit 2 as received, which is the low bit of the emphasis field.
- R5: In professional mode the CRC uses the generator x^8+x^4+x^3+x^2+1 with a preset of 0xFF. Each bit b updates the register c by fb = c[7]^b, then c = {c[6:0],0} ^ (fb ? 0x1D : 0). Bits 0 to 183 are processed. Bit 184+k must equal c[k]. On any mismatch the completed block raises `crc_err_o` = 1.
- R6: In consumer mode no CRC is checked. `crc_err_o` is 0 after every completed block, and the flags update on every completed block.
- R7: A professional block that fails its CRC leaves `audio_o` and `copy_emph_o` unchanged.
- R8: `blk_done_o` is high for exactly one cycle. That cycle is the one after the cycle in which bit 191 is accepted.
- R9: A bit with `blk_start_i` high is always taken as bit 0 of a new block. Any partial block is dropped, with no done pulse and no flag change.
- R10: Bits that arrive with no block started are ignored. This covers bits after reset before the first start marker and bits after bit 191 before the next marker. They cause no done pulse and no output change.
- R11: `crc_err_o` keeps its value until the next completed block, including while a partial block is dropped.
- R12: A bit is counted only in a cycle with `cs_valid_i` high. Idle cycles between bits do not disturb the block. `blk_start_i` has effect only together with `cs_valid_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_bit_i | input | 1 | Channel-status bit of the current frame |
| cs_valid_i | input | 1 | Qualifies `cs_bit_i` |
| blk_start_i | input | 1 | Marks the bit as bit 0 of a block |
| prof_mode_i | input | 1 | 1 = professional, 0 = consumer; sampled with bit 0 |
| audio_o | output | 1 | 1 = audio content, 0 = non-audio |
| copy_emph_o | output | 1 | Copy-inhibit flag (consumer) or low emphasis bit (professional) |
| crc_err_o | output | 1 | CRC mismatch on the last completed block |
| blk_done_o | output | 1 | One-cycle pulse per completed block |

## Verification
A bit counter that slips by even one position shows first at the done pulse, which then arrives a cycle early or late, or not at all. It shows next as CRC errors on blocks that are correct. Both appear one cycle after the expected last bit. A corrupt CRC register, or a received check byte assembled in the wrong order, shows only on professional blocks, as a wrong `crc_err_o` in that same cycle. A mode or flag latch sampled at the wrong index shows as swapped or stale flag values after the block completes. The bench therefore sends blocks whose bits 1 and 2 differ from the block before.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

    localparam int CS_BLOCK_BITS = 192;
    localparam int CS_CRC_W      = 8;
    localparam logic [CS_CRC_W-1:0] CS_CRC_POLY = 8'h1D;
    localparam logic [CS_CRC_W-1:0] CS_CRC_INIT = 8'hFF;

    // Serial positions inside byte 0 that the flags decode
    localparam int CS_IDX_AUDIO = 1;
    localparam int CS_IDX_FLAG2 = 2;

    typedef struct packed {
        logic audio;
        logic copy_emph;
        logic crc_err;
        logic done;
    } cs_flags_t;

endpackage

// File: rtl/cs_blk_tracker.sv
module cs_blk_tracker #(
    parameter  int BLOCK_BITS = 192,
    localparam int CNT_W      = $clog2(BLOCK_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_valid_i,
    input  logic             blk_start_i,
    output logic             take_o,
    output logic             first_o,
    output logic             last_o,
    output logic [CNT_W-1:0] idx_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             active;
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        idx_o   = blk_start_i ? '0 : st_q.cnt;
        take_o  = bit_valid_i & (blk_start_i | st_q.active);
        first_o = take_o & blk_start_i;
        last_o  = take_o & (idx_o == CNT_W'(BLOCK_BITS - 1));
        if (take_o) begin
            st_d.cnt    = idx_o + CNT_W'(1);
            st_d.active = ~last_o;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/cs_crc_engine.sv
module cs_crc_engine #(
    parameter int                 CRC_W = 8,
    parameter logic [CRC_W-1:0]   POLY  = 8'h1D,
    parameter logic [CRC_W-1:0]   INIT  = 8'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic             shift_i,
    input  logic             din_i,
    output logic [CRC_W-1:0] crc_o
);

    logic [CRC_W-1:0] crc_d, crc_q;
    logic [CRC_W-1:0] base;
    logic             fb;

    always_comb begin
        base  = init_i ? INIT : crc_q;
        fb    = base[CRC_W-1] ^ din_i;
        crc_d = base;
        if (shift_i) begin
            crc_d = {base[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= INIT;
        end else begin
            crc_q <= crc_d;
        end
    end

    assign crc_o = crc_q;

endmodule

// File: rtl/cs_status_decoder.sv
module cs_status_decoder
    import cs_dec_pkg::*;
#(
    parameter  int                 BLOCK_BITS = CS_BLOCK_BITS,
    parameter  int                 CRC_W      = CS_CRC_W,
    parameter  logic [CRC_W-1:0]   CRC_POLY   = CS_CRC_POLY,
    parameter  logic [CRC_W-1:0]   CRC_INIT   = CS_CRC_INIT,
    localparam int                 CNT_W      = $clog2(BLOCK_BITS + 1),
    localparam int                 CRC_START  = BLOCK_BITS - CRC_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_bit_i,
    input  logic cs_valid_i,
    input  logic blk_start_i,
    input  logic prof_mode_i,
    output logic audio_o,
    output logic copy_emph_o,
    output logic crc_err_o,
    output logic blk_done_o
);

    typedef struct packed {
        logic             prof;
        logic             b_audio;
        logic             b_flag2;
        logic [CRC_W-1:0] rx_crc;
        cs_flags_t        flags;
    } dec_t;

    dec_t st_d, st_q;

    logic             take, first, last;
    logic [CNT_W-1:0] idx;
    logic [CRC_W-1:0] crc_calc;
    logic [CRC_W-1:0] rx_next;
    logic             crc_bad;
    logic             cur_prof;

    cs_blk_tracker #(
        .BLOCK_BITS (BLOCK_BITS)
    ) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_valid_i (cs_valid_i),
        .blk_start_i (blk_start_i),
        .take_o      (take),
        .first_o     (first),
        .last_o      (last),
        .idx_o       (idx)
    );

    cs_crc_engine #(
        .CRC_W (CRC_W),
        .POLY  (CRC_POLY),
        .INIT  (CRC_INIT)
    ) u_crc (
        .clk     (clk),
        .rst_n   (rst_n),
        .init_i  (first),
        .shift_i (take && (idx < CNT_W'(CRC_START))),
        .din_i   (cs_bit_i),
        .crc_o   (crc_calc)
    );

    // Received check byte, first arriving bit lands in the low position
    for (genvar k = 0; k < CRC_W; k++) begin : g_rx
        assign rx_next[k] = (take && idx == CNT_W'(CRC_START + k)) ? cs_bit_i
                                                                   : st_q.rx_crc[k];
    end

    assign crc_bad  = (rx_next != crc_calc);
    assign cur_prof = first ? prof_mode_i : st_q.prof;

    always_comb begin
        st_d            = st_q;
        st_d.flags.done = 1'b0;
        st_d.rx_crc     = rx_next;
        st_d.prof       = cur_prof;
        if (take && idx == CNT_W'(CS_IDX_AUDIO)) st_d.b_audio = cs_bit_i;
        if (take && idx == CNT_W'(CS_IDX_FLAG2)) st_d.b_flag2 = cs_bit_i;
        if (last) begin
            st_d.flags.done    = 1'b1;
            st_d.flags.crc_err = cur_prof & crc_bad;
            if (!(cur_prof & crc_bad)) begin
                st_d.flags.audio     = ~st_q.b_audio;
                st_d.flags.copy_emph = cur_prof ? st_q.b_flag2 : ~st_q.b_flag2;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.rx_crc <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign audio_o     = st_q.flags.audio;
    assign copy_emph_o = st_q.flags.copy_emph;
    assign crc_err_o   = st_q.flags.crc_err;
    assign blk_done_o  = st_q.flags.done;

endmodule

// File: rtl/cs_status_decoder_chk.sv
module cs_status_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_valid_i,
    input logic audio_o,
    input logic copy_emph_o,
    input logic crc_err_o,
    input logic blk_done_o
);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done_o |=> !blk_done_o);

    // R8
    done_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done_o |-> $past(cs_valid_i));

    // R11
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_done_o |-> $stable(crc_err_o));

    // R7
    fail_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done_o && crc_err_o) |-> ($stable(audio_o) && $stable(copy_emph_o)));

    // R10
    flags_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_done_o |-> ($stable(audio_o) && $stable(copy_emph_o)));

endmodule

bind cs_status_decoder cs_status_decoder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_valid_i  (cs_valid_i),
    .audio_o     (audio_o),
    .copy_emph_o (copy_emph_o),
    .crc_err_o   (crc_err_o),
    .blk_done_o  (blk_done_o)
);

// File: tb/cs_status_decoder_tb.sv
module cs_status_decoder_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_bit_i = 1'b0, cs_valid_i = 1'b0, blk_start_i = 1'b0, prof_mode_i = 1'b0;
    logic audio_o, copy_emph_o, crc_err_o, blk_done_o;

    int n_run = 0, n_fail = 0, done_cnt = 0;
    logic blk [192];

    always #4 clk = ~clk;

    always @(posedge clk) if (blk_done_o) done_cnt <= done_cnt + 1;

    cs_status_decoder u_dut (
        .clk (clk), .rst_n (rst_n), .cs_bit_i (cs_bit_i), .cs_valid_i (cs_valid_i),
        .blk_start_i (blk_start_i), .prof_mode_i (prof_mode_i), .audio_o (audio_o),
        .copy_emph_o (copy_emph_o), .crc_err_o (crc_err_o), .blk_done_o (blk_done_o)
    );

    // {prof, bit1, bit2, corrupt, exp_audio, exp_copy_emph, exp_err}
    localparam logic [6:0] VEC [7] = '{
        7'b0_00_0_110, 7'b0_11_0_000, 7'b1_01_0_110, 7'b1_10_0_000,
        7'b1_00_1_001, 7'b0_10_1_010, 7'b1_11_0_010
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic build(logic prof, logic b1, logic b2, logic bad, int seed);
        logic [7:0] c = 8'hFF;
        logic fb;
        for (int i = 0; i < 192; i++) blk[i] = ((i * 7 + seed) % 3) == 0;
        blk[0] = prof; blk[1] = b1; blk[2] = b2;
        for (int i = 0; i < 184; i++) begin
            fb = c[7] ^ blk[i];
            c  = {c[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
        end
        for (int k = 0; k < 8; k++) blk[184 + k] = c[k];
        if (bad) blk[186] = ~blk[186];
    endtask

    task automatic send(int nbits, bit with_start, bit gaps);
        prof_mode_i = blk[0];
        for (int i = 0; i < nbits; i++) begin
            if (gaps && (i % 3 == 1)) begin
                @(negedge clk); cs_valid_i = 1'b0; blk_start_i = 1'b0; cs_bit_i = ~blk[i];
            end
            @(negedge clk);
            cs_valid_i  = 1'b1;
            blk_start_i = with_start && (i == 0);
            cs_bit_i    = blk[i % 192];
        end
        @(negedge clk);
        cs_valid_i = 1'b0; blk_start_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int base;
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1 audio", audio_o, 0);
        check("R1 copy_emph", copy_emph_o, 0);
        check("R1 crc_err", crc_err_o, 0);
        check("R1 done", blk_done_o, 0);
        rst_n = 1'b1;

        // R10 bits without a start marker after reset
        build(1'b0, 1'b0, 1'b0, 1'b0, 1);
        send(200, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        check("R10 no done before start", done_cnt, 0);
        check("R10 audio untouched", audio_o, 0);

        // Vector walk: R2 R3 R4 R5 R6 R7 R8
        foreach (VEC[v]) begin
            build(VEC[v][6], VEC[v][5], VEC[v][4], VEC[v][3], v + 2);
            send(192, 1'b1, 1'b0);
            check("R8 done pulse", blk_done_o, 1);
            check("R2 audio", audio_o, VEC[v][2]);
            check(VEC[v][6] ? "R4 copy_emph pro" : "R3 copy_emph consumer", copy_emph_o, VEC[v][1]);
            check(VEC[v][6] ? "R5 crc_err" : "R6 crc_err", crc_err_o, VEC[v][0]);
            @(negedge clk);
            check("R8 done one cycle", blk_done_o, 0);
        end
        @(negedge clk);
        check("R8 done count", done_cnt, 7);

        // R9 partial block dropped by a new start marker
        base = done_cnt;
        build(1'b1, 1'b0, 1'b0, 1'b0, 11);
        send(100, 1'b1, 1'b0);
        repeat (2) @(negedge clk);
        check("R9 no done on partial", done_cnt, base);
        check("R9 audio unchanged", audio_o, 0);
        build(1'b0, 1'b0, 1'b1, 1'b0, 12);
        send(192, 1'b1, 1'b0);
        check("R9 new block done", blk_done_o, 1);
        check("R9 audio", audio_o, 1);
        check("R3 copy_emph", copy_emph_o, 0);
        @(negedge clk);
        check("R9 done count", done_cnt, base + 1);

        // R11 error held across a partial block
        build(1'b1, 1'b1, 1'b1, 1'b1, 13);
        send(192, 1'b1, 1'b0);
        check("R5 bad crc", crc_err_o, 1);
        check("R7 audio held", audio_o, 1);
        check("R7 copy_emph held", copy_emph_o, 0);
        build(1'b0, 1'b1, 1'b1, 1'b0, 14);
        send(60, 1'b1, 1'b0);
        repeat (2) @(negedge clk);
        check("R11 err held", crc_err_o, 1);
        send(192, 1'b1, 1'b0);
        check("R11 err cleared", crc_err_o, 0);
        check("R6 flags updated", {audio_o, copy_emph_o}, 2'b00);

        // R10 bits after a completed block without a new start marker
        base = done_cnt + 1;
        build(1'b1, 1'b0, 1'b1, 1'b0, 15);
        send(30, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        check("R10 extra bits no done", done_cnt, base);
        check("R10 extra bits no change", {audio_o, copy_emph_o, crc_err_o}, 3'b000);

        // R12 idle cycles between bits
        build(1'b1, 1'b1, 1'b1, 1'b0, 16);
        send(192, 1'b1, 1'b1);
        check("R12 done with gaps", blk_done_o, 1);
        check("R12 audio", audio_o, 0);
        check("R12 copy_emph", copy_emph_o, 1);
        check("R12 crc ok", crc_err_o, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule